// File: doc/BRIEF.md
# Dual-Clock Posted-Write Timer

This block is a 32-bit up-counter whose count clock is chosen between an internal free-running clock and an external pin. When the pin is chosen, the counter counts pulses that arrive on it. Software reaches the block through a small register port clocked by a separate bus clock. Writes to the control, reload and count registers pass into the counting domain through a toggle request and acknowledge pair. Each direction of that pair has a two-flop synchronizer, so a write is recorded only after the counting clock has ticked a few times. A capture input latches the running count on a chosen edge. A sticky flag records each wrap of the counter past all ones; on a wrap the counter restarts from the reload value.

The request port follows valid/ready rules. A transfer happens on a bus clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high the requester must hold address, direction and write data steady. Reads are never back-pressured, and `rsp_rdata` is valid in the accepting cycle. Writes to the three crossing registers depend on the write mode. In non-posted mode the block holds `req_ready` low until the counting domain has taken the value. In posted mode the write is accepted at once and a per-register pending bit is raised. Software should pick posted mode and finish setup before it switches to the external pin, because any later write waits on pin pulses. The `fclk_sel` input may change only while the counter is disabled.

Top module: `dual_clk_timer`

## Requirements
- R1: After reset every readable register returns 0, no pending or error bit is set, and `req_ready` is high.
- R2: While enabled (CTRL bit 0) the count rises by one on each counting clock edge; while disabled it holds.
- R3: With `fclk_sel`=1 the counter advances only on pulses of `fclk_ext`; with the pin idle the count does not move.
- R4: When the count wraps from all ones it reloads the LOAD value and sets STATUS bit 0 (sticky). Writing 1 to that bit clears it.
- R5: Writes to CTRL (addr 0), LOAD (addr 1) and COUNT (addr 2) are taken on the third counting-clock edge after launch, never earlier than the second. The pending bits (STATUS bits 1, 2, 3 for CTRL, LOAD, COUNT) stay set until the acknowledge has come back.
- R6: With CTRL bit 1 (posted) set, a write is accepted in its first cycle and sets the pending bit of its register.
- R7: With CTRL bit 1 clear, a write to a crossing register holds `req_ready` low until the counting domain has taken it.
- R8: A posted write to a register that is still pending is accepted but dropped. It sets STATUS bit 4 (sticky, cleared by writing 1). The earlier value stays in the register.
- R9: CTRL bits 3:2 choose the capture edge of `cap_in`: 00 off, 01 rising, 10 falling, 11 both. CAPT (addr 3) holds the count seen at the last chosen edge.
- R10: COUNT and CAPT reads return a whole snapshot passed through a synchronized handshake. The snapshot never mixes bits from two counts, and it holds still while the counting clock is idle.
- R11: CTRL (low 4 bits) and LOAD read back the last write that was accepted and not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| fclk_int | input | 1 | Internal counting clock |
| fclk_ext | input | 1 | External pulse pin used as counting clock |
| fclk_sel | input | 1 | 1 selects `fclk_ext`; change only while disabled |
| cap_in | input | 1 | Capture trigger input |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with valid |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 3 | Register address (0 CTRL, 1 LOAD, 2 COUNT, 3 CAPT, 4 STATUS) |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the accepting read cycle |

## Verification
The bench holds the external pin idle and checks that a posted write stays pending. It then sends single pulses and checks that the write is not taken after one pulse and is taken after three. A design with a one-flop crossing, or one that samples data before the request is synchronized, would finish too early. A design that blocks on posted writes would fail the zero-stall check. A second posted write to a pending register must raise the error bit and leave the first value in place; a design that overwrites the held value would show the new data on readback. The bench also checks four more cases:
- A non-posted write must keep `ready` low for dozens of idle-pin cycles.
- The wrap-reload must land near the reload value, not near zero.
- Each capture mode must ignore the edges it does not select.
- A snapshot read taken while the pin is idle must not change.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int ADDR_W = 3;
  localparam int NUM_XREG = 3;
  localparam int CTRL_W = 3;  // {cap_mode[1:0], enable}
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_LOAD  = 3'd1,
    A_COUNT = 3'd2,
    A_CAPT  = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/dct_sync2.sv
module dct_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dct_wr_chan.sv
module dct_wr_chan #(
  parameter int W = 32
) (
  input  logic         bclk,
  input  logic         fclk,
  input  logic         rst_n,
  input  logic         launch,
  input  logic [W-1:0] wdata,
  output logic         pending,
  output logic         f_take,
  output logic [W-1:0] f_data
);
  logic         req_tgl, ack_s;
  logic         req_s, ack_tgl;
  logic [W-1:0] hold_q;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      hold_q  <= '0;
    end else if (launch) begin
      req_tgl <= ~req_tgl;
      hold_q  <= wdata;
    end
  end

  dct_sync2 #(.W(1)) u_ack_sync (.clk(bclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));
  assign pending = req_tgl ^ ack_s;

  dct_sync2 #(.W(1)) u_req_sync (.clk(fclk), .rst_n(rst_n), .d(req_tgl), .q(req_s));
  assign f_take = req_s ^ ack_tgl;
  assign f_data = hold_q;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) ack_tgl <= 1'b0;
    else if (f_take) ack_tgl <= req_s;
  end

  // R5
  launch_idle_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    launch |-> !pending);
  // R5
  take_once_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    f_take |=> !f_take);
endmodule

// File: rtl/dct_snap.sv
module dct_snap #(
  parameter int W = 64
) (
  input  logic         fclk,
  input  logic         bclk,
  input  logic         rst_n,
  input  logic [W-1:0] f_data,
  output logic [W-1:0] b_data
);
  logic         req_tgl, ack_s, req_s, ack_tgl;
  logic [W-1:0] hold_q;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      hold_q  <= '0;
    end else if (req_tgl == ack_s) begin
      hold_q  <= f_data;
      req_tgl <= ~req_tgl;
    end
  end

  dct_sync2 #(.W(1)) u_ack_sync (.clk(fclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));
  dct_sync2 #(.W(1)) u_req_sync (.clk(bclk), .rst_n(rst_n), .d(req_tgl), .q(req_s));

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl <= 1'b0;
      b_data  <= '0;
    end else if (req_s != ack_tgl) begin
      ack_tgl <= req_s;
      b_data  <= hold_q;
    end
  end

  // R10
  snap_hold_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    (req_s == ack_tgl) |=> $stable(b_data));
endmodule

// File: rtl/dct_core.sv
module dct_core #(
  parameter int CNT_W = 32
) (
  input  logic                     fclk,
  input  logic                     rst_n,
  input  logic                     ctrl_take,
  input  logic [dct_pkg::CTRL_W-1:0] ctrl_data,
  input  logic                     load_take,
  input  logic [CNT_W-1:0]         load_data,
  input  logic                     cnt_take,
  input  logic [CNT_W-1:0]         cnt_data,
  input  logic                     cap_in,
  output logic [CNT_W-1:0]         count_q,
  output logic [CNT_W-1:0]         capt_q,
  output logic                     ovf_tgl
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  logic             en_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] load_q;
  logic             cap_s, cap_d, hit;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 2'b00;
      load_q <= '0;
    end else begin
      if (ctrl_take) {mode_q, en_q} <= ctrl_data;
      if (load_take) load_q <= load_data;
    end
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_tgl <= 1'b0;
    end else if (cnt_take) begin
      count_q <= cnt_data;
    end else if (en_q) begin
      if (count_q == ALL_ONES) begin
        count_q <= load_q;
        ovf_tgl <= ~ovf_tgl;
      end else begin
        count_q <= count_q + 1'b1;
      end
    end
  end

  dct_sync2 #(.W(1)) u_cap_sync (.clk(fclk), .rst_n(rst_n), .d(cap_in), .q(cap_s));

  always_comb begin
    unique case (mode_q)
      2'b01:   hit = cap_s & ~cap_d;
      2'b10:   hit = ~cap_s & cap_d;
      2'b11:   hit = cap_s ^ cap_d;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d  <= 1'b0;
      capt_q <= '0;
    end else begin
      cap_d <= cap_s;
      if (hit) capt_q <= count_q;
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (en_q && !cnt_take && count_q != ALL_ONES) |=> count_q == $past(count_q) + 1'b1);
  // R2
  hold_idle_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (!en_q && !cnt_take) |=> $stable(count_q));
  // R4
  wrap_reload_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (en_q && !cnt_take && count_q == ALL_ONES) |=> (count_q == $past(load_q)) && (ovf_tgl != $past(ovf_tgl)));
  // R9
  cap_off_chk: assert property (@(posedge fclk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> $stable(capt_q));
endmodule

// File: rtl/dual_clk_timer.sv
module dual_clk_timer #(
  parameter int CNT_W = 32
) (
  input  logic                       bus_clk,
  input  logic                       rst_n,
  input  logic                       fclk_int,
  input  logic                       fclk_ext,
  input  logic                       fclk_sel,
  input  logic                       cap_in,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [dct_pkg::ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]           req_wdata,
  output logic [CNT_W-1:0]           rsp_rdata
);
  import dct_pkg::*;
  localparam int NX = NUM_XREG;

  logic fclk;
  assign fclk = fclk_sel ? fclk_ext : fclk_int;

  logic [NX-1:0]    pend, launch_v;
  logic [3:0]       pend4;
  logic             is_x, sel_pend, acc_wr, keep_wr, drop_wr;
  logic             posted_q, launched_q, err_q, ovf_q, ovf_s, ovf_d;
  logic [3:0]       ctrl_sh;
  logic [CNT_W-1:0] load_sh;
  logic [1:0]       idx;

  assign is_x     = req_addr < 3'(NX);
  assign idx      = req_addr[1:0];
  assign pend4    = {1'b0, pend};
  assign sel_pend = is_x && pend4[idx];

  always_comb begin
    req_ready = 1'b1;
    if (req_valid && req_write && is_x && !posted_q)
      req_ready = launched_q && !sel_pend;
  end

  assign acc_wr  = req_valid && req_ready && req_write;
  assign keep_wr = acc_wr && is_x && !sel_pend;
  assign drop_wr = acc_wr && is_x && sel_pend;

  for (genvar i = 0; i < NX; i++) begin : g_launch
    assign launch_v[i] = req_valid && req_write && is_x && (idx == 2'(i)) &&
                         !pend[i] && (posted_q || !launched_q);
  end

  always_ff @(posedge bus_clk or negedge rst_n) begin
    if (!rst_n) begin
      posted_q   <= 1'b0;
      launched_q <= 1'b0;
      err_q      <= 1'b0;
      ovf_q      <= 1'b0;
      ovf_d      <= 1'b0;
      ctrl_sh    <= '0;
      load_sh    <= '0;
    end else begin
      if (req_valid && req_ready) launched_q <= 1'b0;
      else if (|launch_v && !posted_q) launched_q <= 1'b1;
      if (keep_wr && req_addr == A_CTRL) begin
        ctrl_sh  <= req_wdata[3:0];
        posted_q <= req_wdata[1];
      end
      if (keep_wr && req_addr == A_LOAD) load_sh <= req_wdata;
      ovf_d <= ovf_s;
      if (ovf_s != ovf_d) ovf_q <= 1'b1;
      else if (acc_wr && req_addr == A_STAT && req_wdata[0]) ovf_q <= 1'b0;
      if (drop_wr) err_q <= 1'b1;
      else if (acc_wr && req_addr == A_STAT && req_wdata[4]) err_q <= 1'b0;
    end
  end

  logic                 ctrl_take, load_take, cnt_take;
  logic [CTRL_W-1:0]    ctrl_f;
  logic [CNT_W-1:0]     load_f, cnt_f, count_f, capt_f, count_b, capt_b;
  logic                 ovf_tgl;

  dct_wr_chan #(.W(CTRL_W)) u_ctrl_chan (
    .bclk(bus_clk), .fclk(fclk), .rst_n(rst_n), .launch(launch_v[0]),
    .wdata({req_wdata[3:2], req_wdata[0]}), .pending(pend[0]),
    .f_take(ctrl_take), .f_data(ctrl_f));
  dct_wr_chan #(.W(CNT_W)) u_load_chan (
    .bclk(bus_clk), .fclk(fclk), .rst_n(rst_n), .launch(launch_v[1]),
    .wdata(req_wdata), .pending(pend[1]), .f_take(load_take), .f_data(load_f));
  dct_wr_chan #(.W(CNT_W)) u_cnt_chan (
    .bclk(bus_clk), .fclk(fclk), .rst_n(rst_n), .launch(launch_v[2]),
    .wdata(req_wdata), .pending(pend[2]), .f_take(cnt_take), .f_data(cnt_f));

  dct_core #(.CNT_W(CNT_W)) u_core (
    .fclk(fclk), .rst_n(rst_n), .ctrl_take(ctrl_take), .ctrl_data(ctrl_f),
    .load_take(load_take), .load_data(load_f), .cnt_take(cnt_take),
    .cnt_data(cnt_f), .cap_in(cap_in), .count_q(count_f), .capt_q(capt_f),
    .ovf_tgl(ovf_tgl));

  dct_snap #(.W(2*CNT_W)) u_snap (
    .fclk(fclk), .bclk(bus_clk), .rst_n(rst_n),
    .f_data({count_f, capt_f}), .b_data({count_b, capt_b}));

  dct_sync2 #(.W(1)) u_ovf_sync (.clk(bus_clk), .rst_n(rst_n), .d(ovf_tgl), .q(ovf_s));

  always_comb begin
    unique case (req_addr)
      A_CTRL:  rsp_rdata = {{(CNT_W-4){1'b0}}, ctrl_sh};
      A_LOAD:  rsp_rdata = load_sh;
      A_COUNT: rsp_rdata = count_b;
      A_CAPT:  rsp_rdata = capt_b;
      A_STAT:  rsp_rdata = {{(CNT_W-5){1'b0}}, err_q, pend, ovf_q};
      default: rsp_rdata = '0;
    endcase
  end

  // R7
  np_idle_accept_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && is_x && !posted_q) |-> !sel_pend);
  // R8
  drop_err_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && is_x && posted_q && sel_pend) |=> err_q);
  // R6
  posted_pend_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (|launch_v) |=> (|pend));
  // R4
  ovf_sticky_chk: assert property (@(posedge bus_clk) disable iff (!rst_n)
    (ovf_q && !(req_valid && req_write && req_addr == A_STAT)) |=> ovf_q);
endmodule

// File: tb/dual_clk_timer_tb.sv
module dual_clk_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {write, addr, data, expected read}
  localparam bit [67:0] VEC [0:NV-1] = '{
    {1'b1, 3'd1, 32'h1234_5678, 32'h0},
    {1'b0, 3'd1, 32'h0,         32'h1234_5678},
    {1'b1, 3'd0, 32'h0000_0002, 32'h0},
    {1'b0, 3'd0, 32'h0,         32'h0000_0002},
    {1'b1, 3'd1, 32'hCAFE_0001, 32'h0},
    {1'b0, 3'd1, 32'h0,         32'hCAFE_0001},
    {1'b1, 3'd0, 32'h0000_0000, 32'h0},
    {1'b0, 3'd0, 32'h0,         32'h0000_0000}
  };

  logic bus_clk = 0, fclk_int = 0, fclk_ext = 0, fclk_sel = 0, cap_in = 0;
  logic rst_n = 0, req_valid = 0, req_write = 0, req_ready;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rsp_rdata;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) bus_clk = ~bus_clk;
  always #7 fclk_int = ~fclk_int;

  dual_clk_timer u_dut (
    .bus_clk(bus_clk), .rst_n(rst_n), .fclk_int(fclk_int), .fclk_ext(fclk_ext),
    .fclk_sel(fclk_sel), .cap_in(cap_in), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic chk_true(input string tag, input bit ok, input logic [31:0] got);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=condition", tag, got);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, output int cyc);
    cyc = 0;
    @(negedge bus_clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready && cyc < 5000) begin
      @(negedge bus_clk); #1; cyc++;
    end
    @(posedge bus_clk); #1;
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    int c;
    bus_wr(a, d, c);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge bus_clk);
    req_valid = 1; req_write = 0; req_addr = a;
    #1 d = rsp_rdata;
    @(posedge bus_clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      fclk_ext = 1; idle(3);
      fclk_ext = 0; idle(3);
    end
  endtask

  initial begin
    logic [31:0] v, a, b, c, c1, c2, c3;
    int cyc;
    bit done;
    idle(5);
    rst_n = 1;
    idle(2);
    // R1 reset state
    #1 chk("R1 ready", {31'b0, req_ready}, 32'd1);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd2, v); chk("R1 count", v, 0);
    rd(3'd3, v); chk("R1 capt", v, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd1, v); chk("R1 load", v, 0);

    // R11 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) wr(VEC[i][66:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][66:64], v);
        chk("R11 readback", v, VEC[i][31:0]);
      end
    end
    idle(30);

    // R2 counting and hold
    wr(3'd2, 32'd100); wr(3'd0, 32'h1);
    idle(40); rd(3'd2, c1);
    chk_true("R2 count rises", c1 > 100, c1);
    wr(3'd0, 32'h0); idle(40); rd(3'd2, c2);
    chk_true("R2 still rising", c2 > c1, c2);
    idle(40); rd(3'd2, c3);
    chk("R10 snapshot stable when disabled", c3, c2);

    // R4 wrap reload and sticky flag
    wr(3'd1, 32'd5); wr(3'd2, 32'hFFFF_FFF0); wr(3'd0, 32'h1);
    idle(60); wr(3'd0, 32'h0); idle(30);
    rd(3'd4, v); chk("R4 overflow flag", v, 32'h1);
    rd(3'd2, v); chk_true("R4 reload value", v >= 5 && v < 200, v);
    wr(3'd4, 32'h1); idle(5);
    rd(3'd4, v); chk("R4 flag cleared", v, 0);

    // R9 capture modes
    wr(3'd2, 32'd0); wr(3'd0, 32'h5); idle(30);
    cap_in = 1; idle(30); rd(3'd3, a);
    chk_true("R9 rising capture", a != 0, a);
    idle(30); rd(3'd3, v); chk("R9 no retrigger", v, a);
    cap_in = 0; idle(30); rd(3'd3, v); chk("R9 fall ignored in rise mode", v, a);
    wr(3'd0, 32'h9); idle(30);
    cap_in = 1; idle(30); rd(3'd3, v); chk("R9 rise ignored in fall mode", v, a);
    cap_in = 0; idle(30); rd(3'd3, b);
    chk_true("R9 falling capture", b > a, b);
    wr(3'd0, 32'hD); idle(30);
    cap_in = 1; idle(30); rd(3'd3, c);
    chk_true("R9 both-edge capture", c > b, c);
    wr(3'd0, 32'h1); idle(30);
    cap_in = 0; idle(30); rd(3'd3, v); chk("R9 mode off", v, c);
    wr(3'd0, 32'h2); idle(30);

    // external clock, posted mode set before switching
    fclk_sel = 1; idle(5);
    bus_wr(3'd1, 32'hAAAA, cyc);
    chk("R6 posted no stall", cyc, 0);
    rd(3'd4, v); chk("R6 load pending", v, 32'h4);
    idle(20); rd(3'd4, v); chk("R5 pending with idle pin", v, 32'h4);
    wr(3'd1, 32'hBBBB);
    rd(3'd4, v); chk("R8 error bit", v, 32'h14);
    rd(3'd1, v); chk("R8 first value kept", v, 32'hAAAA);
    pulse(1); idle(20);
    rd(3'd4, v); chk("R5 one edge not enough", v, 32'h14);
    pulse(3); idle(20);
    rd(3'd4, v); chk("R5 taken after edges", v, 32'h10);
    wr(3'd4, 32'h10); idle(3);
    rd(3'd4, v); chk("R8 error cleared", v, 0);

    // R3 external pulse counting
    wr(3'd2, 32'd0); wr(3'd0, 32'h3);
    pulse(8); idle(20);
    rd(3'd4, v); chk("R5 both taken", v, 0);
    rd(3'd2, a); chk_true("R3 counted pulses", a >= 1 && a <= 8, a);
    idle(50); rd(3'd2, b); chk("R3 idle pin holds", b, a);
    pulse(10); idle(20);
    rd(3'd2, b); chk_true("R3 pulses advance", b > a && b <= a + 13, b);

    // R7 non-posted stall
    wr(3'd0, 32'h1); pulse(4); idle(20);
    done = 0;
    fork
      begin bus_wr(3'd1, 32'h77, cyc); done = 1; end
      begin
        idle(30);
        chk("R7 write stalled", {31'b0, done}, 0);
        pulse(4);
      end
    join
    chk_true("R7 stall length", done && cyc >= 30, cyc);
    rd(3'd1, v); chk("R7 value recorded", v, 32'h77);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge bus_clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule